// File: doc/BRIEF.md
# Receive Character Buffer with Per-Entry Error Tags

This block sits between a serial receiver and the processor side of a serial port. The receiver offers each finished character together with three error tags: parity, framing and break. The block stores up to sixteen such entries in arrival order. The processor removes characters one at a time. The error tags it sees are always those of the character at the head. Any tag carried by a later entry stays hidden until that entry reaches the head.

Around the storage the block produces the status a line-status and interrupt layer needs. These are a fill count, a data-ready bit, a sticky overrun bit, and a sticky bit that says an errored entry is somewhere in the buffer. There is also a fill-threshold flag with four selectable levels, and a character-timeout flag. The timeout is measured in ticks of the 16x receive clock enable. Its window is four character times. The length of one character, counted in bits, arrives on an input from the active frame format, and a frame with two stop bits counts both of them.

The timeout runs as a three-state machine. TM_EMPTY is the state while the buffer holds nothing. TM_EMPTY goes to TM_RUN as soon as an entry is stored. TM_RUN restarts its tick counter on any accepted push or pop. TM_RUN goes to TM_FIRED when the counter reaches the window length, and goes back to TM_EMPTY when the buffer drains or is cleared. TM_FIRED ignores pushes. TM_FIRED goes to TM_RUN on a pop that leaves data behind, and goes to TM_EMPTY on a pop that empties the buffer or on a clear.

Top module: `rx_err_fifo`

## Requirements
- R1: Characters leave in the order they were accepted. The fill count `count` never exceeds 16. While the buffer is not empty, `rd_data` shows the head character.
- R2: After reset, `count` is 0 and `data_ready`, `overrun`, `fifo_err`, `trig_hit`, `timeout` and `head_err` are all 0. `data_ready` is 1 exactly while `count` is nonzero.
- R3: A push that arrives while the buffer holds 16 entries, with no pop in the same cycle, is discarded and sets `overrun`. `overrun` clears on `lsr_read`. If a new discard happens in the same cycle as `lsr_read`, the set wins.
- R4: `trig_hit` is 1 while `count` is at least the selected level. The levels are: `trig_sel`=00 gives 1, 01 gives 4, 10 gives 8, and 11 gives 14.
- R5: The tags on `head_err` belong to the head entry: bit 0 is parity, bit 1 is framing and bit 2 is break. `head_err` is 0 when the buffer is empty.
- R6: `fifo_err` sets when an entry with any nonzero tag is accepted. On `lsr_read` it clears only if no stored entry still carries a tag once that cycle's pop has been applied.
- R7: With data stored and no accepted push or pop, `timeout` rises after exactly 64 × `char_bits` cycles in which `tick16` is high. Cycles with `tick16` low do not count.
- R8: Before `timeout` fires, an accepted push or pop restarts the tick count. Once it has fired, a push leaves `timeout` set.
- R9: When `timeout` is set, one accepted pop clears it. If data remains, the full window starts again.
- R10: `clear` empties the buffer, zeroes the fill count, the tag count and the timer, and clears `fifo_err` and `timeout`. It leaves `overrun` unchanged. A push or pop in the same cycle is ignored.
- R11: A pop on an empty buffer changes no state. `rd_data` keeps the value of the last character popped, which is 0 after reset.
- R12: A push and a pop in the same cycle on a full buffer are both accepted. The count stays at 16 and `overrun` does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at the 16x bit rate |
| clear | input | 1 | Empty the buffer and restart its counters |
| push | input | 1 | Receiver offers a completed character |
| push_data | input | 8 | Offered character |
| push_err | input | 3 | Offered tags: bit 0 parity, bit 1 framing, bit 2 break |
| pop | input | 1 | Processor removes the head character |
| lsr_read | input | 1 | Line status has been read |
| trig_sel | input | 2 | Fill threshold select |
| char_bits | input | 4 | Bits per character in the current frame format |
| rd_data | output | 8 | Head character, or the last popped character when empty |
| head_err | output | 3 | Tags of the head entry |
| count | output | 5 | Number of stored entries |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky overrun |
| fifo_err | output | 1 | Sticky: a tagged entry is stored |
| trig_hit | output | 1 | Fill count at or above the selected level |
| timeout | output | 1 | Character timeout |

## Verification
The states that are hardest to reach are the exact edge of the timeout window and the case where `fifo_err` must survive an `lsr_read`. The bench holds `tick16` high and counts steps to land one cycle short of the window and then on it. It does this both from a fresh push and from a restart part-way through the window. For the sticky error bit, the fill sweep tags every entry with a rotating pattern. The line status is read half-way through draining, while tagged entries are still queued, and again once the last one has left.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        TM_EMPTY = 2'd0,
        TM_RUN   = 2'd1,
        TM_FIRED = 2'd2
    } tm_state_e;

    // Level code to threshold: 1, quarter, half, depth minus two.
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ERR_W  = 3,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push_ok,
    input  logic              pop_ok,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ERR_W-1:0]  werr,
    output logic [CW-1:0]     count,
    output logic [DATA_W-1:0] head_data,
    output logic [ERR_W-1:0]  head_err,
    output logic [DATA_W-1:0] last_data
);

    logic [DATA_W-1:0] dmem [DEPTH];
    logic [ERR_W-1:0]  emem [DEPTH];
    logic [AW-1:0]     wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            dmem[wptr] <= wdata;
            emem[wptr] <= werr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            last_data <= '0;
        end else if (clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok) begin
                rptr      <= bump(rptr);
                last_data <= dmem[rptr];
            end
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    assign head_data = dmem[rptr];
    assign head_err  = emem[rptr];

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic lsr_read,
    input  logic push_ok,
    input  logic push_drop,
    input  logic push_tagged,
    input  logic pop_ok,
    input  logic head_tagged,
    output logic overrun,
    output logic fifo_err
);

    logic [CW-1:0] tag_cnt, tag_cnt_nx;

    always_comb begin
        if (clear) tag_cnt_nx = '0;
        else       tag_cnt_nx = tag_cnt + CW'(push_ok && push_tagged)
                                        - CW'(pop_ok && head_tagged);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_cnt  <= '0;
            overrun  <= 1'b0;
            fifo_err <= 1'b0;
        end else begin
            tag_cnt <= tag_cnt_nx;
            if (push_drop)     overrun <= 1'b1;
            else if (lsr_read) overrun <= 1'b0;
            if (clear)                                fifo_err <= 1'b0;
            else if (push_ok && push_tagged)          fifo_err <= 1'b1;
            else if (lsr_read && tag_cnt_nx == '0)    fifo_err <= 1'b0;
        end
    end

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout
    import rxf_pkg::*;
#(
    parameter int TO_CHARS      = 4,
    parameter int TICKS_PER_BIT = 16,
    parameter int CB_W          = 4,
    localparam int LIM_W = $clog2(TO_CHARS * TICKS_PER_BIT * ((1 << CB_W) - 1) + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            push_ok,
    input  logic            pop_ok,
    input  logic            nonempty_nx,
    input  logic [CB_W-1:0] char_bits,
    output logic            timeout
);

    tm_state_e        state, state_nx;
    logic [LIM_W-1:0] tcnt, tcnt_nx, tcnt_inc, limit;

    assign limit    = LIM_W'(TO_CHARS * TICKS_PER_BIT) * LIM_W'(char_bits);
    assign tcnt_inc = tcnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TM_EMPTY;
            tcnt  <= '0;
        end else begin
            state <= state_nx;
            tcnt  <= tcnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        tcnt_nx  = tcnt;
        unique case (state)
            TM_EMPTY: begin
                tcnt_nx = '0;
                if (nonempty_nx) state_nx = TM_RUN;
            end
            TM_RUN: begin
                if (!nonempty_nx) begin
                    state_nx = TM_EMPTY;
                    tcnt_nx  = '0;
                end else if (push_ok || pop_ok) begin
                    tcnt_nx = '0;
                end else if (tick) begin
                    if (tcnt_inc >= limit) begin
                        state_nx = TM_FIRED;
                        tcnt_nx  = '0;
                    end else begin
                        tcnt_nx = tcnt_inc;
                    end
                end
            end
            TM_FIRED: begin
                tcnt_nx = '0;
                if (!nonempty_nx) state_nx = TM_EMPTY;
                else if (pop_ok)  state_nx = TM_RUN;
            end
            default: begin
                state_nx = TM_EMPTY;
                tcnt_nx  = '0;
            end
        endcase
    end

    always_comb begin
        timeout = (state == TM_FIRED);
    end

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxf_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int DEPTH         = 16,
    parameter int TO_CHARS      = 4,
    parameter int TICKS_PER_BIT = 16,
    parameter int CB_W          = 4,
    localparam int ERR_W        = 3,
    localparam int CW           = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ERR_W-1:0]  push_err,
    input  logic              pop,
    input  logic              lsr_read,
    input  logic [1:0]        trig_sel,
    input  logic [CB_W-1:0]   char_bits,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  head_err,
    output logic [CW-1:0]     count,
    output logic              data_ready,
    output logic              overrun,
    output logic              fifo_err,
    output logic              trig_hit,
    output logic              timeout
);

    logic              pop_ok, push_ok, push_drop, nonempty_nx;
    logic [CW-1:0]     cnt_after;
    logic [DATA_W-1:0] head_data, last_data;
    logic [ERR_W-1:0]  head_raw;

    always_comb begin
        pop_ok      = pop && (count != '0) && !clear;
        push_ok     = push && !clear && ((count != CW'(DEPTH)) || pop_ok);
        push_drop   = push && !clear && !push_ok;
        cnt_after   = count + CW'(push_ok) - CW'(pop_ok);
        nonempty_nx = !clear && (cnt_after != '0);
    end

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ERR_W(ERR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .wdata     (push_data),
        .werr      (push_err),
        .count     (count),
        .head_data (head_data),
        .head_err  (head_raw),
        .last_data (last_data)
    );

    rxf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .lsr_read    (lsr_read),
        .push_ok     (push_ok),
        .push_drop   (push_drop),
        .push_tagged (|push_err),
        .pop_ok      (pop_ok),
        .head_tagged (|head_raw),
        .overrun     (overrun),
        .fifo_err    (fifo_err)
    );

    rxf_timeout #(.TO_CHARS(TO_CHARS), .TICKS_PER_BIT(TICKS_PER_BIT), .CB_W(CB_W)) u_timeout (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .push_ok     (push_ok),
        .pop_ok      (pop_ok),
        .nonempty_nx (nonempty_nx),
        .char_bits   (char_bits),
        .timeout     (timeout)
    );

    always_comb begin
        data_ready = (count != '0);
        rd_data    = data_ready ? head_data : last_data;
        head_err   = data_ready ? head_raw : '0;
        trig_hit   = (count >= CW'(trig_level(trig_sel, DEPTH)));
    end

endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic              pop,
    input logic              clear,
    input logic              lsr_read,
    input logic [1:0]        trig_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic [CW-1:0]     count,
    input logic              data_ready,
    input logic              overrun,
    input logic              fifo_err,
    input logic              trig_hit,
    input logic              timeout
);

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r3_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear && count == CW'(DEPTH)) |=> (overrun && count == CW'(DEPTH)));

    a_r4_lowest_level: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 2'b00) |-> (trig_hit == data_ready));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err && !lsr_read && !clear) |=> fifo_err);

    a_r7_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> data_ready);

    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !timeout && !fifo_err));

    a_r11_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clear && !data_ready) |=> ($stable(rd_data) && !data_ready));

endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .pop        (pop),
    .clear      (clear),
    .lsr_read   (lsr_read),
    .trig_sel   (trig_sel),
    .rd_data    (rd_data),
    .count      (count),
    .data_ready (data_ready),
    .overrun    (overrun),
    .fifo_err   (fifo_err),
    .trig_hit   (trig_hit),
    .timeout    (timeout)
);

// File: tb/rx_err_fifo_tb.sv
module rx_err_fifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0, clear = 1'b0, push = 1'b0, pop = 1'b0, lsr_read = 1'b0;
    logic [7:0] push_data = '0;
    logic [2:0] push_err = '0;
    logic [1:0] trig_sel = '0;
    logic [3:0] char_bits = 4'd7;
    logic [7:0] rd_data;
    logic [2:0] head_err;
    logic [4:0] count;
    logic       data_ready, overrun, fifo_err, trig_hit, timeout;

    always #5 clk = ~clk;

    rx_err_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .clear(clear), .push(push),
        .push_data(push_data), .push_err(push_err), .pop(pop), .lsr_read(lsr_read),
        .trig_sel(trig_sel), .char_bits(char_bits), .rd_data(rd_data), .head_err(head_err),
        .count(count), .data_ready(data_ready), .overrun(overrun), .fifo_err(fifo_err),
        .trig_hit(trig_hit), .timeout(timeout)
    );

    int vec = 0, bad = 0;
    logic [7:0] md [16];
    logic [2:0] me [16];
    int         mc = 0;
    logic       mo = 0, mf = 0;
    logic [7:0] ml = '0;

    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1", "count", int'(count), mc);
        chk("R2", "data_ready", int'(data_ready), int'(mc > 0));
        chk("R1", "rd_data", int'(rd_data), (mc > 0) ? int'(md[0]) : int'(ml));
        chk("R5", "head_err", int'(head_err), (mc > 0) ? int'(me[0]) : 0);
        chk("R3", "overrun", int'(overrun), int'(mo));
        chk("R6", "fifo_err", int'(fifo_err), int'(mf));
        chk("R4", "trig_hit", int'(trig_hit), int'(mc >= lvl(trig_sel)));
    endtask

    task automatic step(input bit p, input logic [7:0] d, input logic [2:0] e,
                        input bit q, input bit l, input bit c, input bit t);
        bit pop_ok, push_ok, drop;
        int rem;
        push = p; push_data = d; push_err = e; pop = q; lsr_read = l; clear = c; tick16 = t;
        @(posedge clk);
        #1;
        push = 0; pop = 0; lsr_read = 0; clear = 0; tick16 = 0;
        pop_ok  = q && mc > 0 && !c;
        push_ok = p && !c && (mc < 16 || pop_ok);
        drop    = p && !c && !push_ok;
        if (c) mc = 0;
        else begin
            if (pop_ok) begin
                ml = md[0];
                for (int i = 0; i < 15; i++) begin md[i] = md[i+1]; me[i] = me[i+1]; end
                mc--;
            end
            if (push_ok) begin md[mc] = d; me[mc] = e; mc++; end
        end
        rem = 0;
        for (int i = 0; i < mc; i++) if (me[i] != 0) rem++;
        if (drop) mo = 1; else if (l) mo = 0;
        if (c) mf = 0;
        else if (push_ok && e != 0) mf = 1;
        else if (l && rem == 0) mf = 0;
    endtask

    task automatic idle(input int n, input bit t);
        for (int i = 0; i < n; i++) step(0, 8'h00, 3'b000, 0, 0, 0, t);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int lim;
        repeat (3) @(posedge clk);
        #1;
        // R2: reset state
        compare();
        chk("R2", "timeout after reset", int'(timeout), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Fill sweep with rotating tags and all threshold codes at each level (R1, R4, R5)
        for (int i = 0; i < 16; i++) begin
            step(1, 8'((i * 37 + 5) & 255), 3'(i % 8), 0, 0, 0, 0);
            compare();
            for (int s = 0; s < 4; s++) begin
                trig_sel = 2'(s);
                #1;
                chk("R4", "trig sweep", int'(trig_hit), int'(mc >= lvl(trig_sel)));
            end
            trig_sel = 2'b00;
        end

        // R3: push on full is dropped
        step(1, 8'hEE, 3'b000, 0, 0, 0, 0);
        compare();
        chk("R3", "count stays full", int'(count), 16);
        chk("R3", "overrun set", int'(overrun), 1);
        step(0, 8'h00, 3'b000, 0, 1, 0, 0);
        compare();
        chk("R6", "fifo_err kept while tags remain", int'(fifo_err), 1);

        // R12: push and pop together when full
        step(1, 8'hA5, 3'b100, 1, 0, 0, 0);
        compare();
        chk("R12", "no overrun on push+pop", int'(overrun), 0);

        // Drain, reading line status midway (R1, R5, R6)
        for (int i = 0; i < 16; i++) begin
            step(0, 8'h00, 3'b000, 1, (i == 8), 0, 0);
            compare();
        end
        chk("R6", "fifo_err survives drain", int'(fifo_err), 1);
        step(0, 8'h00, 3'b000, 0, 1, 0, 0);
        compare();
        chk("R6", "fifo_err clears when none left", int'(fifo_err), 0);

        // R11: pop on empty
        step(0, 8'h00, 3'b000, 1, 0, 0, 0);
        compare();
        chk("R11", "rd_data holds last", int'(rd_data), int'(ml));
        chk("R11", "count stays 0", int'(count), 0);

        // R7: exact timeout window, char_bits = 7
        lim = 64 * 7;
        step(1, 8'h31, 3'b000, 0, 0, 0, 1);
        idle(lim - 1, 1);
        chk("R7", "not fired one tick short", int'(timeout), 0);
        idle(1, 1);
        chk("R7", "fired at window", int'(timeout), 1);
        // R8: push after firing keeps it set
        step(1, 8'h32, 3'b000, 0, 0, 0, 1);
        chk("R8", "push keeps timeout", int'(timeout), 1);
        // R9: pop clears and restarts
        step(0, 8'h00, 3'b000, 1, 0, 0, 1);
        compare();
        chk("R9", "pop clears timeout", int'(timeout), 0);
        idle(lim - 1, 1);
        chk("R9", "restarted window short", int'(timeout), 0);
        idle(1, 1);
        chk("R9", "restarted window full", int'(timeout), 1);

        // R7: ticks low do not count
        step(0, 8'h00, 3'b000, 1, 0, 0, 0);
        step(1, 8'h40, 3'b000, 0, 0, 0, 0);
        idle(1000, 0);
        chk("R7", "no ticks no timeout", int'(timeout), 0);

        // R8: push mid-window restarts
        idle(200, 1);
        step(1, 8'h41, 3'b001, 0, 0, 0, 1);
        idle(lim - 1, 1);
        chk("R8", "restart by push short", int'(timeout), 0);
        idle(1, 1);
        chk("R8", "restart by push full", int'(timeout), 1);

        // R10: clear while fired, with overrun pending
        for (int i = 0; i < 15; i++) step(1, 8'(i), 3'b000, 0, 0, 0, 0);
        step(1, 8'hFF, 3'b000, 0, 0, 0, 0);
        compare();
        step(0, 8'h00, 3'b000, 0, 0, 1, 0);
        compare();
        chk("R10", "count zero", int'(count), 0);
        chk("R10", "timeout cleared", int'(timeout), 0);
        chk("R10", "overrun kept", int'(overrun), 1);
        step(1, 8'h77, 3'b010, 0, 0, 1, 0);
        compare();
        chk("R10", "push during clear ignored", int'(count), 0);
        step(0, 8'h00, 3'b000, 0, 1, 0, 0);
        compare();

        // R7: longer frame, char_bits = 12
        char_bits = 4'd12;
        lim = 64 * 12;
        step(1, 8'h5A, 3'b000, 0, 0, 0, 1);
        idle(lim - 1, 1);
        chk("R7", "12-bit frame short", int'(timeout), 0);
        idle(1, 1);
        chk("R7", "12-bit frame full", int'(timeout), 1);
        step(0, 8'h00, 3'b000, 1, 0, 0, 1);
        compare();
        chk("R9", "pop to empty clears", int'(timeout), 0);

        finish_run();
    end

endmodule